// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single line. Written bytes go into a 16-entry queue and leave in the order they were written. A frame engine takes one byte at a time from the queue. It sends a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. While no frame is being sent the line stays high.

The frame layout comes from a packed mode byte, and a separate input selects odd or even parity. Both are captured at the moment a character starts. Bit timing comes from a sampling tick that runs at sixteen times the bit rate. That tick comes from one of two places: an internal divider that fires every `baud_div + 1` clock cycles, or the rising edges of an external clock input after resynchronisation. An active-low clear-to-send input must be asserted before a new character may start. The current queue fill, an empty flag and a one-cycle overflow pulse are reported at all times.

The frame engine has five named states:
- IDLE: the line is high. The engine leaves for START when the queue holds data and clear-to-send is asserted, and it pops the head byte in that same cycle.
- START: the line is low. The engine moves to DATA after 16 ticks.
- DATA: the engine shifts out 7 or 8 bits, 16 ticks each. After the last bit it goes to PARITY if parity is on, and to STOP otherwise.
- PARITY: the engine sends one bit, then goes to STOP.
- STOP: the line is high for 16 or 32 ticks, then the engine returns to IDLE.

Top module: `fifo_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `fill_count` is 0, `empty` is 1 and `overflow` is 0.
- R2: Each frame begins with one low start bit, followed by the data bits least significant first. `mode[6]` = 1 sends 7 data bits (`wr_data[6:0]`), and `mode[6]` = 0 sends 8 bits.
- R3: `mode[5]` = 1 appends a parity bit after the data bits, and `mode[5]` = 0 sends none. The parity bit makes the number of ones in the data bits plus the parity bit odd when `parity_odd` = 1, and even when `parity_odd` = 0.
- R4: `mode[3]` = 0 sends one high stop bit and `mode[3]` = 1 sends two. All other mode bits are ignored.
- R5: Every bit lasts 16 sampling ticks. With `clk_sel` = 0, a tick occurs once every `baud_div + 1` clock cycles.
- R6: With `clk_sel` = 1, each rising edge of `ext_clk16` gives one tick, after a two-stage synchroniser. The internal divider is then unused.
- R7: Bytes leave in write order. `fill_count` runs from 0 to 16 and reflects every accepted write and every character start. `empty` is 1 exactly when `fill_count` is 0.
- R8: A write while `fill_count` is 16 is discarded and `overflow` goes high for one cycle. `fill_count` stays at 16.
- R9: No character starts while `cts_n` is high, as seen after a two-stage synchroniser. A character that has already started always completes, even if `cts_n` rises partway through it.
- R10: `mode` and `parity_odd` are captured when a character starts. Changing them mid-character does not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to enqueue |
| mode | input | 8 | Frame format: bit 6 selects 7 data bits, bit 5 enables parity, bit 3 selects two stop bits |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| clk_sel | input | 1 | 0 uses the internal divider, 1 uses the external tick clock |
| baud_div | input | DIVW | Internal divider: a tick every baud_div+1 cycles |
| ext_clk16 | input | 1 | External clock at 16 times the bit rate |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial output, idle high |
| fill_count | output | $clog2(DEPTH+1) | Number of queued bytes |
| empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | One-cycle pulse when a write is dropped |

## Verification
The bench builds the block with its default depth of 16 and a 12-bit divider.

It drives `baud_div` at 0, so a tick fires every cycle and a bit lasts exactly 16 clocks. At that speed it can sweep all sixteen combinations of data length, parity enable, stop length and parity sense, with several bytes under each.

It then fills the whole queue past its limit while clear-to-send is held off. It also runs `baud_div` = 2 and an external tick clock with a period of four clocks. Against these runs the bench checks the queue order, the overflow boundary and the bit duration arithmetically.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    // bit positions inside the packed mode byte
    localparam int MODE_SEVEN_BIT = 6;
    localparam int MODE_PAR_BIT   = 5;
    localparam int MODE_STOP_BIT  = 3;

    localparam int TICKS_PER_BIT  = 16;

    typedef struct packed {
        logic seven;
        logic par_en;
        logic two_stop;
    } tx_fmt_t;

endpackage

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && full;
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/tx_tick_gen.sv
module tx_tick_gen #(
    parameter int DIVW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            use_ext,
    input  logic [DIVW-1:0] div,
    input  logic            ext_clk,
    output logic            tick
);

    logic [DIVW-1:0] cnt;
    logic [2:0]      ext_sync;
    logic            int_tick, ext_tick;

    assign int_tick = !use_ext && (cnt >= div);
    assign ext_tick = use_ext && ext_sync[1] && !ext_sync[2];
    assign tick     = int_tick || ext_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            ext_sync <= '0;
        end else begin
            ext_sync <= {ext_sync[1:0], ext_clk};
            if (use_ext || cnt >= div) cnt <= '0;
            else                       cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       avail,
    input  logic       cts_ok,
    input  logic [7:0] data,
    input  tx_fmt_t    fmt_in,
    input  logic       odd_in,
    output logic       pop,
    output logic       txd,
    output tx_state_t  state,
    output tx_fmt_t    fmt_q
);

    tx_state_t state_n;
    logic [3:0] sub;
    logic [2:0] nbit;
    logic [7:0] shreg;
    logic       par_q;
    logic       bit_end, go;
    logic [2:0] last_data, last_stop;
    logic [7:0] mask;

    assign bit_end   = tick && (sub == 4'(TICKS_PER_BIT - 1));
    assign last_data = fmt_q.seven ? 3'd6 : 3'd7;
    assign last_stop = fmt_q.two_stop ? 3'd1 : 3'd0;
    assign go        = (state == ST_IDLE) && avail && cts_ok;
    assign pop       = go;
    assign mask      = fmt_in.seven ? 8'h7F : 8'hFF;

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (go) state_n = ST_START;
            ST_START:  if (bit_end) state_n = ST_DATA;
            ST_DATA:   if (bit_end && nbit == last_data)
                           state_n = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_n = ST_STOP;
            ST_STOP:   if (bit_end && nbit == last_stop) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub   <= '0;
            nbit  <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            fmt_q <= '0;
        end else if (go) begin
            sub   <= '0;
            nbit  <= '0;
            shreg <= data;
            fmt_q <= fmt_in;
            par_q <= (^(data & mask)) ^ odd_in;
        end else if (state != ST_IDLE && tick) begin
            sub <= sub + 1'b1;
            if (bit_end) begin
                nbit <= (state_n != state) ? 3'd0 : nbit + 1'b1;
                if (state == ST_DATA) shreg <= {1'b0, shreg[7:1]};
            end
        end
    end

    // line output
    always_comb begin
        unique case (state)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIVW  = 12,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      mode,
    input  logic            parity_odd,
    input  logic            clk_sel,
    input  logic [DIVW-1:0] baud_div,
    input  logic            ext_clk16,
    input  logic            cts_n,
    output logic            txd,
    output logic [CW-1:0]   fill_count,
    output logic            empty,
    output logic            overflow
);

    logic       tick, pop, cts_ok;
    logic [1:0] cts_sync;
    logic [7:0] head;
    tx_fmt_t    fmt_in, fmt_q;
    tx_state_t  state;

    assign fmt_in = '{seven:    mode[MODE_SEVEN_BIT],
                      par_en:   mode[MODE_PAR_BIT],
                      two_stop: mode[MODE_STOP_BIT]};
    assign cts_ok = !cts_sync[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cts_sync <= 2'b11;
        else        cts_sync <= {cts_sync[0], cts_n};
    end

    tx_byte_queue #(.DEPTH(DEPTH), .W(8)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (pop),
        .dout  (head),
        .count (fill_count),
        .empty (empty),
        .ovf   (overflow)
    );

    tx_tick_gen #(.DIVW(DIVW)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_ext (clk_sel),
        .div     (baud_div),
        .ext_clk (ext_clk16),
        .tick    (tick)
    );

    tx_frame_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .avail  (!empty),
        .cts_ok (cts_ok),
        .data   (head),
        .fmt_in (fmt_in),
        .odd_in (parity_odd),
        .pop    (pop),
        .txd    (txd),
        .state  (state),
        .fmt_q  (fmt_q)
    );

endmodule

// File: rtl/fifo_uart_tx_chk.sv
module fifo_uart_tx_chk
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          overflow,
    input logic [CW-1:0] fill_count,
    input tx_state_t     state,
    input tx_fmt_t       fmt_q,
    input logic          tick,
    input logic          cts_ok
);

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    // R8
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(wr_en) && $past(fill_count) == CW'(DEPTH)));

    // R9
    cts_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) == ST_IDLE) |-> $past(cts_ok));

    // R10
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(fmt_q));

    // R5
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state) && $past(state) != ST_IDLE) |-> $past(tick));

endmodule

bind fifo_uart_tx fifo_uart_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .overflow   (overflow),
    .fill_count (fill_count),
    .state      (state),
    .fmt_q      (fmt_q),
    .tick       (tick),
    .cts_ok     (cts_ok)
);

// File: tb/fifo_uart_tx_test.sv
`timescale 1ns/1ps
module fifo_uart_tx_test;

    localparam int DEPTH = 16;
    localparam int DIVW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [7:0]      mode = '0;
    logic            parity_odd = 1'b0;
    logic            clk_sel = 1'b0;
    logic [DIVW-1:0] baud_div = '0;
    logic            ext_clk16 = 1'b0;
    logic            cts_n = 1'b1;
    logic            txd;
    logic [4:0]      fill_count;
    logic            empty;
    logic            overflow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    fifo_uart_tx #(.DEPTH(DEPTH), .DIVW(DIVW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mode(mode), .parity_odd(parity_odd), .clk_sel(clk_sel),
        .baud_div(baud_div), .ext_clk16(ext_clk16), .cts_n(cts_n),
        .txd(txd), .fill_count(fill_count), .empty(empty), .overflow(overflow)
    );

    always #10 clk = ~clk;

    // external tick clock: period of four system clocks
    initial forever begin
        @(posedge clk); @(posedge clk);
        ext_clk16 <= ~ext_clk16;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks = checks + 1;
        if (act < lo || act > hi) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // receive one frame; bitc = clock cycles per bit
    task automatic rx_frame(input int bitc, input logic seven, input logic pe,
                            input logic two, input logic odd, input logic [7:0] exp);
        int guard;
        int nb;
        logic [7:0] got;
        logic par_exp;
        guard = 0;
        while (txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        check("R2 start found", int'(guard < 4000), 1);
        nb = seven ? 7 : 8;
        got = '0;
        wait_cyc(bitc / 2);
        check("R2 start bit low", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            wait_cyc(bitc);
            got[i] = txd;
        end
        check("R2 data bits", int'(got), int'(seven ? (exp & 8'h7F) : exp));
        if (pe) begin
            wait_cyc(bitc);
            par_exp = (^(seven ? (exp & 8'h7F) : exp)) ^ odd;
            check("R3 parity bit", int'(txd), int'(par_exp));
        end
        wait_cyc(bitc);
        check("R4 first stop bit", int'(txd), 1);
        if (two) begin
            wait_cyc(bitc);
            check("R4 second stop bit", int'(txd), 1);
        end
        wait_cyc(bitc / 2);
    endtask

    // measure start bit length of an 8N1 frame of 0xFF
    task automatic meas_start(output int len);
        int guard;
        guard = 0;
        while (txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        len = 0;
        while (txd === 1'b0 && len < 4000) begin
            @(negedge clk);
            len++;
        end
    endtask

    initial begin
        int len;
        logic [7:0] b;
        wait_cyc(4);
        // R1: reset state
        check("R1 txd idle", int'(txd), 1);
        check("R1 count", int'(fill_count), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 overflow", int'(overflow), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1 txd after release", int'(txd), 1);

        // R2 R3 R4: sweep every format
        cts_n = 1'b0;
        wait_cyc(3);
        for (int f = 0; f < 16; f++) begin
            mode = '0;
            mode[6] = f[0];
            mode[5] = f[1];
            mode[3] = f[2];
            mode[7] = f[0];     // unused bits toggled (R4 ignored)
            mode[0] = f[1];
            parity_odd = f[3];
            for (int k = 0; k < 4; k++) begin
                b = 8'((f * 37 + k * 91 + 5) & 8'hFF);
                write_byte(b);
                rx_frame(16, f[0], f[1], f[2], f[3], b);
            end
        end
        wait_cyc(20);
        check("R7 empty after sweep", int'(empty), 1);

        // R8 R9 R7: fill while clear-to-send held off
        mode = '0;
        parity_odd = 1'b0;
        cts_n = 1'b1;
        wait_cyc(4);
        for (int k = 0; k < 16; k++) begin
            write_byte(8'(k * 13 + 1));
            check("R7 count rises", int'(fill_count), k + 1);
        end
        check("R7 not empty when full", int'(empty), 0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 overflow pulse", int'(overflow), 1);
        check("R8 count stays 16", int'(fill_count), 16);
        @(negedge clk);
        check("R8 overflow one cycle", int'(overflow), 0);
        wait_cyc(100);
        check("R9 no start while cts off", int'(txd), 1);
        check("R9 count held", int'(fill_count), 16);

        // R9: deassert mid-character, it completes
        cts_n = 1'b0;
        fork
            rx_frame(16, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
            begin
                wait_cyc(60);
                cts_n = 1'b1;
            end
        join
        wait_cyc(200);
        check("R9 line stays idle", int'(txd), 1);
        check("R9 count after one", int'(fill_count), 15);
        cts_n = 1'b0;
        for (int k = 1; k < 16; k++) begin
            rx_frame(16, 1'b0, 1'b0, 1'b0, 1'b0, 8'(k * 13 + 1));
        end
        wait_cyc(20);
        check("R7 drained", int'(fill_count), 0);

        // R10: format change mid-character
        write_byte(8'hA7);
        fork
            rx_frame(16, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA7);
            begin
                wait_cyc(40);
                mode = 8'h68;
                parity_odd = 1'b1;
            end
        join
        wait_cyc(20);
        mode = '0;
        parity_odd = 1'b0;

        // R5: divider of 2 gives 48-cycle bits
        baud_div = 12'd2;
        write_byte(8'hFF);
        meas_start(len);
        check_range("R5 start len div2", len, 46, 48);
        wait_cyc(600);
        write_byte(8'h3C);
        rx_frame(48, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);

        // R6: external tick clock, period 4
        clk_sel = 1'b1;
        wait_cyc(10);
        write_byte(8'hFF);
        meas_start(len);
        check_range("R6 start len ext", len, 61, 64);
        wait_cyc(800);
        write_byte(8'h5A);
        rx_frame(64, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A);
        mode = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule